// File: doc/BRIEF.md
# Decimating Complex Bandpass Channel Selector

The block picks one channel out of a stream of complex baseband samples and hands it out at baseband with the sample rate divided by eight. It uses no oscillator and no mixer. A real low-pass prototype is rotated to the channel centre, which makes it a complex bandpass filter. The channel centres are whole multiples of the output rate, so decimating the filtered stream folds the selected channel onto zero frequency. Any mixer that would follow the decimator then has unit value, and the block leaves it out.

The work is done only for the samples the decimator keeps. Each output depends on a 32-sample window. Four slot accumulators each build one of the four outputs whose windows overlap. Every accepted input sample adds one complex product into each slot. A new channel index is latched only on a sample that completes an output. When the index changes, the coefficient table is rebuilt in that same edge. Outputs whose windows still hold products made with the old coefficients are suppressed.

Top module: `chan_select_dec`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o`, `out_re_o` and `out_im_o` are zero. Reset clears the sample counter and sets the active channel to 0.
- R2: Accepted samples are counted from 0 after reset. A sample whose count is a multiple of 8 is an output boundary. It produces one `out_valid_o` pulse in the cycle after it is accepted. `out_valid_o` is low in every other cycle.
- R3: The output for boundary sample i with active channel k is y = Σ_{n=0..31} h(n)·w((k·n) mod 8)·x[i−n]. Here h(n)=n+1 for n<16 and 32−n otherwise. Samples before reset count as zero. The factors w(0..7) are the Q14 pairs (re,im): (16384,0), (11585,11585), (0,16384), (−11585,11585), (−16384,0), (−11585,−11585), (0,−16384), (11585,−11585). This equals mixing by w(−k·i), real FIR filtering with h, and keeping every eighth sample.
- R4: Each of re and im is formed at full precision, has 2^21 added, and is shifted right arithmetically by 22. The result is saturated to [−32768, 32767].
- R5: `chan_i` is sampled only on boundary samples. The output of the boundary where a new index is taken still uses the previous channel. The samples that follow use the new one.
- R6: After a channel change, the next 3 boundaries give no `out_valid_o`. The 4th boundary gives a valid output computed entirely with the new channel. A further change during this hold restarts the count.
- R7: A tone at channel k (x[i]=A·w(k·i)) fed to the block set to channel k settles to a constant output with zero imaginary part. A tone at a different channel settles to a near-zero output.
- R8: Cycles with `in_valid_i` low have no effect: they neither advance the sample count nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_re_i | input | 16 | Input sample, real part, signed |
| in_im_i | input | 16 | Input sample, imaginary part, signed |
| chan_i | input | 3 | Channel index k, sampled on boundaries |
| out_valid_o | output | 1 | Decimated output strobe |
| out_re_o | output | 16 | Output real part, signed |
| out_im_o | output | 16 | Output imaginary part, signed |

## Verification
A retune can arrive on the same boundary sample that completes an output. In that one edge, the block must emit the old-channel result, shift the slot accumulators and rebuild the coefficient table. The bench provokes this by changing `chan_i` between stream segments, so the change always lands on a boundary. It includes a sweep through all eight channels, with gaps in `in_valid_i` inside some segments. The bench judges the outcome with an arithmetic mixer–FIR–decimator model. The model holds the old channel for the boundary output and counts the three suppressed outputs before comparing the first new-channel result.

// File: rtl/chsel_pkg.sv
`timescale 1ns/1ps
package chsel_pkg;
  localparam int M   = 8;                 // decimation; twiddle set below is for 8 phases
  localparam int LG  = $clog2(M);
  localparam int T   = 32;                // prototype length
  localparam int TIW = $clog2(T);
  localparam int P   = T / M;             // overlapping outputs = slot count
  localparam int HCW = $clog2(P) + 1;
  localparam int DW  = 16;
  localparam int TWW = 16;                // Q14 twiddle
  localparam int CW  = 20;                // h(n)*twiddle
  localparam int PW  = DW + CW + 1;
  localparam int AW  = PW + TIW + 1;
  localparam int SH  = 22;

  typedef logic signed [DW-1:0]  data_t;
  typedef logic signed [CW-1:0]  coef_t;
  typedef logic signed [PW-1:0]  prod_t;
  typedef logic signed [AW-1:0]  acc_t;
  typedef logic signed [TWW-1:0] tw_t;

  function automatic int proto_tap(int n);
    return (n < T/2) ? n + 1 : T - n;
  endfunction

  function automatic tw_t tw_re(logic [LG-1:0] a);
    case (a)
      3'd0: return 16'sd16384;
      3'd1: return 16'sd11585;
      3'd2: return 16'sd0;
      3'd3: return -16'sd11585;
      3'd4: return -16'sd16384;
      3'd5: return -16'sd11585;
      3'd6: return 16'sd0;
      default: return 16'sd11585;
    endcase
  endfunction

  function automatic tw_t tw_im(logic [LG-1:0] a);
    case (a)
      3'd0: return 16'sd0;
      3'd1: return 16'sd11585;
      3'd2: return 16'sd16384;
      3'd3: return 16'sd11585;
      3'd4: return 16'sd0;
      3'd5: return -16'sd11585;
      3'd6: return -16'sd16384;
      default: return -16'sd11585;
    endcase
  endfunction
endpackage

// File: rtl/chsel_coef_gen.sv
`timescale 1ns/1ps
module chsel_coef_gen import chsel_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LG-1:0] chan_i,
  output coef_t         coef_re_o [T],
  output coef_t         coef_im_o [T]
);
  for (genvar n = 0; n < T; n++) begin : g_tap
    localparam coef_t HN  = CW'(proto_tap(n));
    localparam coef_t RST = CW'(proto_tap(n) * 16384);
    logic [LG-1:0] ph;
    assign ph = LG'(int'(chan_i) * n);   // (k*n) mod M

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coef_re_o[n] <= RST;
        coef_im_o[n] <= '0;
      end else if (load_i) begin
        coef_re_o[n] <= HN * CW'(tw_re(ph));
        coef_im_o[n] <= HN * CW'(tw_im(ph));
      end
    end
  end
endmodule

// File: rtl/chsel_cmac.sv
`timescale 1ns/1ps
module chsel_cmac import chsel_pkg::*; (
  input  data_t x_re_i,
  input  data_t x_im_i,
  input  coef_t c_re_i,
  input  coef_t c_im_i,
  output prod_t p_re_o,
  output prod_t p_im_o
);
  prod_t xr, xi, cr, ci;
  assign xr = PW'(x_re_i);
  assign xi = PW'(x_im_i);
  assign cr = PW'(c_re_i);
  assign ci = PW'(c_im_i);
  assign p_re_o = xr * cr - xi * ci;
  assign p_im_o = xr * ci + xi * cr;
endmodule

// File: rtl/chsel_round.sv
`timescale 1ns/1ps
module chsel_round import chsel_pkg::*; (
  input  acc_t  acc_i,
  output data_t y_o
);
  localparam acc_t RND  = AW'(64'sd1 << (SH - 1));
  localparam acc_t MAXV = AW'((64'sd1 << (DW - 1)) - 1);
  localparam acc_t MINV = -MAXV - AW'(1);

  acc_t biased, shifted;
  assign biased  = acc_i + RND;
  assign shifted = biased >>> SH;

  always_comb begin
    if (shifted > MAXV)      y_o = MAXV[DW-1:0];
    else if (shifted < MINV) y_o = MINV[DW-1:0];
    else                     y_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/chan_select_dec.sv
`timescale 1ns/1ps
module chan_select_dec import chsel_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [15:0]   in_re_i,
  input  logic signed [15:0]   in_im_i,
  input  logic [2:0]           chan_i,
  output logic                 out_valid_o,
  output logic signed [15:0]   out_re_o,
  output logic signed [15:0]   out_im_o
);
  logic [LG-1:0]  phase_q, nph, chan_q;
  logic [HCW-1:0] hold_q;
  logic           boundary, retune;

  assign boundary = in_valid_i && (phase_q == '0);
  assign retune   = boundary && (chan_i != chan_q);
  assign nph      = LG'(0) - phase_q;     // tap offset for this phase

  coef_t coef_re [T];
  coef_t coef_im [T];

  chsel_coef_gen u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (retune),
    .chan_i   (chan_i),
    .coef_re_o(coef_re),
    .coef_im_o(coef_im)
  );

  prod_t prod_re [P];
  prod_t prod_im [P];
  acc_t  acc_re_q [P];
  acc_t  acc_im_q [P];
  acc_t  sum_re [P];
  acc_t  sum_im [P];

  for (genvar e = 0; e < P; e++) begin : g_slot
    logic [TIW-1:0] cidx;
    assign cidx = TIW'(e * M) + TIW'(nph);

    chsel_cmac u_mac (
      .x_re_i(in_re_i),
      .x_im_i(in_im_i),
      .c_re_i(coef_re[cidx]),
      .c_im_i(coef_im[cidx]),
      .p_re_o(prod_re[e]),
      .p_im_o(prod_im[e])
    );

    assign sum_re[e] = acc_re_q[e] + AW'(prod_re[e]);
    assign sum_im[e] = acc_im_q[e] + AW'(prod_im[e]);

    if (e == P - 1) begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          acc_re_q[e] <= '0;
          acc_im_q[e] <= '0;
        end else if (boundary) begin
          acc_re_q[e] <= '0;
          acc_im_q[e] <= '0;
        end else if (in_valid_i) begin
          acc_re_q[e] <= sum_re[e];
          acc_im_q[e] <= sum_im[e];
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          acc_re_q[e] <= '0;
          acc_im_q[e] <= '0;
        end else if (boundary) begin
          acc_re_q[e] <= sum_re[e+1];
          acc_im_q[e] <= sum_im[e+1];
        end else if (in_valid_i) begin
          acc_re_q[e] <= sum_re[e];
          acc_im_q[e] <= sum_im[e];
        end
      end
    end
  end

  data_t y_re, y_im;
  chsel_round u_rnd_re (.acc_i(sum_re[0]), .y_o(y_re));
  chsel_round u_rnd_im (.acc_i(sum_im[0]), .y_o(y_im));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= '0;
      chan_q      <= '0;
      hold_q      <= '0;
      out_valid_o <= 1'b0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= boundary && (hold_q == '0);
      if (in_valid_i) phase_q <= phase_q + LG'(1);
      if (boundary) begin
        out_re_o <= y_re;
        out_im_o <= y_im;
      end
      if (retune) begin
        chan_q <= chan_i;
        hold_q <= HCW'(P - 1);
      end else if (boundary && hold_q != '0) begin
        hold_q <= hold_q - HCW'(1);
      end
    end
  end

  AST_OUT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(in_valid_i) && $past(phase_q) == '0));            // R2
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(phase_q) && !out_valid_o && $stable(out_re_o))); // R8
  AST_RETUNE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && chan_i != chan_q) |=> (chan_q == $past(chan_i) && hold_q == HCW'(P - 1))); // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && hold_q != '0) |=> !out_valid_o);                            // R6
  AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary |=> (acc_re_q[P-1] == '0 && acc_im_q[P-1] == '0));              // R3
endmodule

// File: tb/sim_chan_select_dec.sv
`timescale 1ns/1ps
module sim_chan_select_dec;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic [2:0] chan = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;

  always #10 clk = ~clk;

  chan_select_dec u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im), .chan_i(chan),
    .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int hist_re [4096];
  int hist_im [4096];
  int n_in = 0;
  int k_m = 0, hold_m = 0;
  int last_re = 0, last_im = 0, prev_re = 0, prev_im = 0;
  int unsigned seed = 32'h1234_5678;
  int twr [8] = '{16384, 11585, 0, -11585, -16384, -11585, 0, 11585};
  int twi [8] = '{0, 11585, 16384, 11585, 0, -11585, -16384, -11585};

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d (sample %0d)", req, got, exp, n_in);
    end
  endtask

  function automatic int sat_round(longint a);
    longint s = (a + (64'sd1 <<< 21)) >>> 22;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  // mixer by w(-k*i), real FIR h, decimate: R3, R4
  task automatic ref_out(input int i, input int k, output int yr, output int yi);
    longint ar = 0, ai = 0;
    for (int n = 0; n < 32; n++) begin
      if (i - n >= 0) begin
        int m = ((-(k * (i - n))) % 8 + 8) % 8;
        longint xr = hist_re[i-n], xi = hist_im[i-n];
        longint mr = xr * twr[m] - xi * twi[m];
        longint mi = xr * twi[m] + xi * twr[m];
        int h = (n < 16) ? n + 1 : 32 - n;
        ar += mr * h;
        ai += mi * h;
      end
    end
    yr = sat_round(ar);
    yi = sat_round(ai);
  endtask

  function automatic int rnd16();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'((seed >> 8) & 32'h7FFF) - 16384;
  endfunction

  task automatic push(input int re, input int im, input int gaps);
    bit bnd;
    bit ev;
    int er, ei;
    string tag;
    for (int g = 0; g < gaps; g++) begin
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R8 idle valid", int'(out_valid), 0);
    end
    in_valid = 1'b1;
    in_re = 16'(re);
    in_im = 16'(im);
    hist_re[n_in] = re;
    hist_im[n_in] = im;
    bnd = (n_in % 8 == 0);
    ev = 0; er = 0; ei = 0; tag = "R3";
    if (bnd) begin
      ref_out(n_in, k_m, er, ei);
      ev = (hold_m == 0);
      if (int'(chan) != k_m) begin
        tag = "R5";
        k_m = int'(chan);
        hold_m = 3;
      end else if (hold_m != 0) begin
        tag = "R6";
        hold_m--;
      end
    end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (bnd) begin
      chk({tag, " valid"}, int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        chk({tag, " re"}, int'(out_re), er);
        chk({tag, " im"}, int'(out_im), ei);
        prev_re = last_re; prev_im = last_im;
        last_re = int'(out_re); last_im = int'(out_im);
      end
    end else begin
      chk("R2 off-boundary valid", int'(out_valid), 0);
    end
    n_in++;
  endtask

  task automatic tone(input int k, input int amp, input int count);
    for (int s = 0; s < count; s++) begin
      int m = (k * n_in) % 8;
      push((amp * twr[m]) / 16384, (amp * twi[m]) / 16384, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset re", int'(out_re), 0);
    chk("R1 reset im", int'(out_im), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // channel 0, contiguous random stream (R1 channel default, R2, R3)
    chan = 3'd0;
    for (int s = 0; s < 80; s++) push(rnd16(), rnd16(), 0);

    // retune to 3 with gaps (R5, R6, R8)
    chan = 3'd3;
    for (int s = 0; s < 96; s++) push(rnd16(), rnd16(), ((seed & 3) == 0) ? 2 : 0);

    // saturation on DC (R4)
    chan = 3'd0;
    for (int s = 0; s < 72; s++) push(32767, 0, 0);
    chk("R4 positive clip", last_re, 32767);
    for (int s = 0; s < 72; s++) push(-32768, 0, 0);
    chk("R4 negative clip", last_re, -32768);

    // on-channel tone to DC, off-channel tone rejected (R7)
    chan = 3'd5;
    tone(5, 8000, 72);
    chk("R7 dc steady re", last_re, prev_re);
    chk("R7 dc steady im", last_im, prev_im);
    chk("R7 dc level", int'(last_re > 4000), 1);
    chk("R7 dc imag zero", int'(last_im >= -1 && last_im <= 1), 1);
    tone(2, 8000, 72);
    chk("R7 off-channel re", int'(last_re >= -8 && last_re <= 8), 1);
    chk("R7 off-channel im", int'(last_im >= -8 && last_im <= 8), 1);

    // sweep all channels (R3, R5, R6)
    for (int k = 0; k < 8; k++) begin
      chan = 3'(k);
      for (int s = 0; s < 48; s++) push(rnd16(), rnd16(), (s % 11 == 3) ? 1 : 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule